// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block owns a small bank of 64-bit control and status registers for a RISC-V core and carries out the atomic swap, bit-set and bit-clear operations on them. Each request lasts one cycle. With the request come the instruction's funct3, its 12-bit immediate field, the rs1 operand, the 5-bit immediate held in the rs1 field, and a flag that says whether the rs1 register index is zero. In that same cycle the unit returns the register's prior contents for the destination register. The modified value is stored at the next clock edge.

The registers sit in a contiguous address window set by parameters. Any access outside the window is flagged as an illegal instruction and changes nothing. The unit also decodes the funct3 = 0 system encodings: it pulses separate outputs for an environment call, a breakpoint and a recognised but unimplemented return encoding, and it leaves all register state untouched for these. Privilege checking, interrupts and trap vectoring are handled elsewhere.

Top module: `csr_unit`

## Requirements
- R1: After reset, every implemented CSR reads as zero. While no request is valid, rdVal and all four flag outputs are low.
- R2: On a valid, legal CSR request, rdVal carries the CSR's value from before the request in that same cycle. The updated value is visible from the next cycle on.
- R3: The swap forms (funct3 = 1 with the register source, funct3 = 5 with the immediate source) always store the source value, even when the source is zero.
- R4: The set forms (funct3 = 2 and 6) store the old value OR the source.
- R5: The clear forms (funct3 = 3 and 7) store the old value AND the inverted source.
- R6: The set and clear forms store nothing when the source counts as zero. For register forms this is whenever rs1IdxZero is 1, whatever rs1Val carries. For immediate forms it is whenever zimm is 0.
- R7: The immediate forms zero-extend zimm to 64 bits and ignore rs1Val.
- R8: Only addresses CSR_BASE to CSR_BASE+NUM_CSR-1 are implemented (0x340 to 0x343 by default). A CSR request to any other address, or any request with funct3 = 4, raises illegalInstr, returns rdVal = 0 and writes nothing.
- R9: With funct3 = 0, csrAddr 0x000 pulses ecallPulse, 0x001 pulses ebreakPulse, and 0x100 pulses unimplPulse. Every other csrAddr value raises illegalInstr. None of these change any CSR, and rdVal stays 0.
- R10: When reqValid is low, no CSR changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per operation |
| funct3 | input | 3 | Operation select |
| csrAddr | input | 12 | CSR address / system function field |
| rs1Val | input | 64 | Register source operand |
| zimm | input | 5 | Immediate source operand |
| rs1IdxZero | input | 1 | rs1 register index is zero |
| rdVal | output | 64 | Prior CSR value for the destination register |
| illegalInstr | output | 1 | Illegal encoding or unimplemented CSR |
| ecallPulse | output | 1 | Environment call decoded |
| ebreakPulse | output | 1 | Breakpoint decoded |
| unimplPulse | output | 1 | Recognised, unimplemented system encoding |

## Verification
The hardest case to observe is a write that is suppressed. A set or clear with a zero operand gives the same result whether or not it writes, so the bench makes suppression visible at the ports. It drives register-form requests with rs1IdxZero high while rs1Val carries a non-zero pattern. A write that wrongly goes ahead then changes the CSR, and the next request's returned old value exposes the change. The sweep runs every funct3 against every implemented address, one unimplemented address and the three system codes. It does this under four source patterns, so each CSR keeps a changing non-zero history, and an arithmetic model in the bench predicts every returned value.

// File: rtl/csr_pkg.sv
package csr_pkg;

  // Low two funct3 bits select the update kind.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [2:0]  F3_SYSTEM    = 3'd0;
  localparam logic [2:0]  F3_RESERVED  = 3'd4;
  localparam logic [11:0] SYS_ECALL    = 12'h000;
  localparam logic [11:0] SYS_EBREAK   = 12'h001;
  localparam logic [11:0] SYS_UNIMPL   = 12'h100;

  // Control to datapath strobes.
  typedef struct packed {
    logic    rdEn;
    logic    wrEn;
    logic    useImm;
    csr_op_e opSel;
  } csr_strobe_t;

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int NUM_CSR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         funct3,
  input  logic [11:0]        csrAddr,
  input  logic [4:0]         zimm,
  input  logic               rs1IdxZero,
  input  logic [NUM_CSR-1:0] addrHit,
  output csr_strobe_t        strobe,
  output logic               illegalInstr,
  output logic               ecallPulse,
  output logic               ebreakPulse,
  output logic               unimplPulse
);

  logic isCsrOp;
  logic legalCsr;
  logic srcZero;
  logic sysOp;
  csr_op_e opKind;

  always_comb begin
    isCsrOp  = (funct3 != F3_SYSTEM) && (funct3 != F3_RESERVED);
    legalCsr = reqValid && isCsrOp && (|addrHit);
    srcZero  = funct3[2] ? (zimm == 5'd0) : rs1IdxZero;
    opKind   = csr_op_e'(funct3[1:0]);
    sysOp    = reqValid && (funct3 == F3_SYSTEM);
  end

  always_comb begin
    strobe.rdEn   = legalCsr;
    strobe.useImm = funct3[2];
    strobe.opSel  = legalCsr ? opKind : OP_NONE;
    strobe.wrEn   = legalCsr && ((opKind == OP_WRITE) || !srcZero);
  end

  always_comb begin
    ecallPulse   = sysOp && (csrAddr == SYS_ECALL);
    ebreakPulse  = sysOp && (csrAddr == SYS_EBREAK);
    unimplPulse  = sysOp && (csrAddr == SYS_UNIMPL);
    illegalInstr = reqValid && !legalCsr && !(ecallPulse || ebreakPulse || unimplPulse);
  end

  // R6: set/clear with zero source never raises the write strobe
  a_r6_zero_src_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (funct3 inside {3'd2, 3'd3}) && rs1IdxZero) |-> !strobe.wrEn);

  a_r6_zero_imm_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (funct3 inside {3'd6, 3'd7}) && (zimm == 5'd0)) |-> !strobe.wrEn);

  // R8: an illegal request must not write
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> !strobe.wrEn);

  // R9: at most one exception-class output at a time, and none write
  a_r9_one_exception: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({illegalInstr, ecallPulse, ebreakPulse, unimplPulse}));

  a_r9_sys_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (ecallPulse || ebreakPulse || unimplPulse) |-> (!strobe.wrEn && !strobe.rdEn));

  // R10: nothing happens without a request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!strobe.wrEn && !illegalInstr && !ecallPulse && !ebreakPulse && !unimplPulse));

endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          NUM_CSR  = 4,
  parameter int          IMM_W    = 5,
  parameter logic [11:0] CSR_BASE = 12'h340
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    rs1Val,
  input  logic [IMM_W-1:0]   zimm,
  input  csr_strobe_t        strobe,
  output logic [NUM_CSR-1:0] addrHit,
  output logic [XLEN-1:0]    rdVal
);

  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] csrQ [NUM_CSR];
  logic [XLEN-1:0] oldVal;
  logic [XLEN-1:0] srcVal;
  logic [XLEN-1:0] newVal;

  for (genvar g = 0; g < NUM_CSR; g++) begin : gHit
    assign addrHit[g] = (csrAddr == 12'(CSR_BASE + 12'(g)));
  end

  always_comb begin
    oldVal = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (addrHit[i]) oldVal = oldVal | csrQ[i];
    end
  end

  always_comb begin
    srcVal = strobe.useImm ? {{PAD_W{1'b0}}, zimm} : rs1Val;
    unique case (strobe.opSel)
      OP_WRITE: newVal = srcVal;
      OP_SET:   newVal = oldVal | srcVal;
      OP_CLEAR: newVal = oldVal & ~srcVal;
      default:  newVal = oldVal;
    endcase
  end

  assign rdVal = strobe.rdEn ? oldVal : '0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CSR; i++) begin
      if (!rstN) begin
        csrQ[i] <= '0;
      end else if (strobe.wrEn && addrHit[i]) begin
        csrQ[i] <= newVal;
      end
    end
  end

  for (genvar g = 0; g < NUM_CSR; g++) begin : gChk
    // R10: a register only moves when the write strobe selects it
    a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wrEn && addrHit[g]) |=> $stable(csrQ[g]));

    // R4: a set never clears a bit
    a_r4_set_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && addrHit[g] && strobe.opSel == OP_SET)
        |=> ((csrQ[g] & $past(csrQ[g])) == $past(csrQ[g])));

    // R5: a clear never sets a bit
    a_r5_clear_no_new_bits: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && addrHit[g] && strobe.opSel == OP_CLEAR)
        |=> ((csrQ[g] & ~$past(csrQ[g])) == '0));
  end

  // R8: at most one implemented register answers an address
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rstN) $onehot0(addrHit));

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          NUM_CSR  = 4,
  parameter int          IMM_W    = 5,
  parameter logic [11:0] CSR_BASE = 12'h340
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      funct3,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [IMM_W-1:0] zimm,
  input  logic            rs1IdxZero,
  output logic [XLEN-1:0] rdVal,
  output logic            illegalInstr,
  output logic            ecallPulse,
  output logic            ebreakPulse,
  output logic            unimplPulse
);

  csr_strobe_t        strobe;
  logic [NUM_CSR-1:0] addrHit;

  csr_ctrl #(.NUM_CSR(NUM_CSR)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .funct3       (funct3),
    .csrAddr      (csrAddr),
    .zimm         (zimm),
    .rs1IdxZero   (rs1IdxZero),
    .addrHit      (addrHit),
    .strobe       (strobe),
    .illegalInstr (illegalInstr),
    .ecallPulse   (ecallPulse),
    .ebreakPulse  (ebreakPulse),
    .unimplPulse  (unimplPulse)
  );

  csr_datapath #(
    .XLEN     (XLEN),
    .NUM_CSR  (NUM_CSR),
    .IMM_W    (IMM_W),
    .CSR_BASE (CSR_BASE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .csrAddr (csrAddr),
    .rs1Val  (rs1Val),
    .zimm    (zimm),
    .strobe  (strobe),
    .addrHit (addrHit),
    .rdVal   (rdVal)
  );

  // R2: old value only returned for a valid request
  a_r2_rd_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (rdVal != '0) |-> reqValid);

endmodule

// File: tb/tb_csr_unit.sv
`timescale 1ns/1ps
module tb_csr_unit;

  localparam int NCSR = 4;
  localparam logic [11:0] BASE = 12'h340;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [11:0] csrAddr = '0;
  logic [63:0] rs1Val = '0;
  logic [4:0]  zimm = '0;
  logic        rs1IdxZero = 1'b0;
  logic [63:0] rdVal;
  logic        illegalInstr, ecallPulse, ebreakPulse, unimplPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] model [NCSR];

  always #2.5 clk = ~clk;

  csr_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .funct3(funct3), .csrAddr(csrAddr),
    .rs1Val(rs1Val), .zimm(zimm), .rs1IdxZero(rs1IdxZero), .rdVal(rdVal),
    .illegalInstr(illegalInstr), .ecallPulse(ecallPulse), .ebreakPulse(ebreakPulse),
    .unimplPulse(unimplPulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] addrOf(input int a);
    case (a)
      0, 1, 2, 3: addrOf = BASE + 12'(a);
      4:          addrOf = 12'h7C0;
      5:          addrOf = 12'h000;
      6:          addrOf = 12'h001;
      default:    addrOf = 12'h100;
    endcase
  endfunction

  // One request: drive after negedge, check combinational outputs, commit at posedge.
  task automatic doOp(input logic [2:0] f3, input logic [11:0] addr, input logic [63:0] rv,
                      input logic [4:0] zi, input logic flag);
    logic legal, zeroSrc, wr;
    int idx;
    logic [63:0] src, nv, expRd;
    string tag;
    @(negedge clk);
    reqValid = 1'b1; funct3 = f3; csrAddr = addr; rs1Val = rv; zimm = zi; rs1IdxZero = flag;
    #1;
    idx = -1;
    for (int i = 0; i < NCSR; i++) if (addr == BASE + 12'(i)) idx = i;
    legal   = (f3 != 3'd0) && (f3 != 3'd4) && (idx >= 0);
    src     = f3[2] ? {59'd0, zi} : rv;
    zeroSrc = f3[2] ? (zi == 5'd0) : flag;
    wr      = legal && ((f3[1:0] == 2'd1) || !zeroSrc);
    expRd   = legal ? model[idx] : 64'd0;
    if (!legal) tag = (f3 == 3'd0) ? "R9" : "R8";
    else if (!wr) tag = "R6";
    else if (f3[2]) tag = "R7";
    else if (f3[1:0] == 2'd1) tag = "R3";
    else if (f3[1:0] == 2'd2) tag = "R4";
    else tag = "R5";
    check({tag, " R2 rdVal"}, rdVal, expRd);
    check({tag, " illegal"}, {63'd0, illegalInstr},
          {63'd0, !legal && !(f3 == 3'd0 && (addr == 12'h000 || addr == 12'h001 || addr == 12'h100))});
    check("R9 exc pulses", {61'd0, ecallPulse, ebreakPulse, unimplPulse},
          {61'd0, f3 == 3'd0 && addr == 12'h000, f3 == 3'd0 && addr == 12'h001,
           f3 == 3'd0 && addr == 12'h100});
    if (wr) begin
      case (f3[1:0])
        2'd1:    nv = src;
        2'd2:    nv = model[idx] | src;
        default: nv = model[idx] & ~src;
      endcase
      model[idx] = nv;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    for (int i = 0; i < NCSR; i++) model[i] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: idle outputs after reset
    check("R1 idle rdVal", rdVal, 64'd0);
    check("R1 idle flags", {60'd0, illegalInstr, ecallPulse, ebreakPulse, unimplPulse}, 64'd0);
    // R1: reset contents via side-effect-free reads
    for (int i = 0; i < NCSR; i++) doOp(3'd2, BASE + 12'(i), 64'hFFFF, 5'd0, 1'b1);

    // Sweep: every funct3, every address class, four source patterns.
    k = 1;
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 8; a++) begin
        for (int p = 0; p < 4; p++) begin
          logic [63:0] v;
          logic [4:0]  zi;
          v  = 64'hA5A5_0F0F_3C3C_9696 ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
          zi = 5'(k * 7 + 3);
          if (zi == 5'd0) zi = 5'd1;
          if (p[1]) zi = 5'd0;
          if (p == 3) v = 64'd0;
          doOp(3'(f), addrOf(a), v, zi, p[0]);
          k++;
        end
      end
    end

    // R3: swap with a zero source really writes zero, register and immediate forms
    doOp(3'd1, BASE, 64'h1234_5678_9ABC_DEF0, 5'd0, 1'b0);
    doOp(3'd1, BASE, 64'd0, 5'd0, 1'b1);
    doOp(3'd2, BASE, 64'd0, 5'd0, 1'b1);
    doOp(3'd5, BASE + 12'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 1'b0);
    doOp(3'd2, BASE + 12'd1, 64'd0, 5'd0, 1'b1);
    // R7: immediate set uses only the zero-extended immediate
    doOp(3'd6, BASE + 12'd2, 64'hFFFF_FFFF_FFFF_FFFF, 5'h1F, 1'b1);
    doOp(3'd2, BASE + 12'd2, 64'd0, 5'd0, 1'b1);

    // R10: inputs with reqValid low change nothing
    @(negedge clk);
    reqValid = 1'b0; funct3 = 3'd1; csrAddr = BASE + 12'd3; rs1Val = 64'hDEAD_BEEF; rs1IdxZero = 1'b0;
    #1;
    check("R10 idle rdVal", rdVal, 64'd0);
    check("R10 idle flags", {60'd0, illegalInstr, ecallPulse, ebreakPulse, unimplPulse}, 64'd0);
    @(posedge clk);
    doOp(3'd2, BASE + 12'd3, 64'd0, 5'd0, 1'b1);

    // Final readback of all registers (R2 visibility)
    for (int i = 0; i < NCSR; i++) doOp(3'd2, BASE + 12'(i), 64'd0, 5'd0, 1'b1);
    idle();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule